// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block turns a prescaled low-frequency tick into LCD frame timing. It groups ticks into multiplex phases and phases into frames. Every phase lasts (divider+1) ticks. A frame holds two passes over the active commons: a normal pass and an inverted pass, so the panel sees no DC component. It emits a one-cycle frame-start strobe, the index of the common being driven, and the multiplex mode currently in force. Waveform levels, bias and segment drivers are left to the blocks that consume these outputs.

The block runs on the system clock and advances only on cycles where `tick` is high. Divider and mode inputs may change at any time. They are sampled only on the first tick of a frame, so a frame never mixes two configurations. Dropping `en` parks the block. When `en` returns, the block arms for one cycle, and the next tick opens a fresh frame.

Its control is a four-state machine:
- `ST_OFF`: disabled, all counters held at zero.
- `ST_START`: armed; the next tick is the first tick of a frame.
- `ST_POS`: the normal half-frame.
- `ST_NEG`: the inverted half-frame.

The transitions are:
- arm: `ST_OFF` to `ST_START` on any cycle with `en` high.
- open: `ST_START` to `ST_POS` on a tick that does not close the half-frame.
- short half: `ST_START` to `ST_NEG` on a tick that does close it.
- flip: `ST_POS` to `ST_NEG` on the tick that ends the last phase of the half.
- close: `ST_NEG` to `ST_START` on the tick that ends the last phase of the frame.
- park: any state to `ST_OFF` while `en` is low.

Top module: `lcd_frame_timer`

## Requirements
- R1: `mux_sel` encodes the mode as 0 = static (1 common), 1 = duplex (2), 2 = triplex (3) and 3 = quadruplex (4). `com_idx` steps 0..N-1 in the normal half-frame, then 0..N-1 again in the inverted half-frame, so `com_idx` never exceeds `mux_active`.
- R2: Each phase lasts exactly `div_sel`+1 ticks, for every divider value 0 to 7. `com_idx` advances one cycle after the tick that ends a phase.
- R3: The number of ticks from one frame start to the next is (`div_sel`+1) x 2 x N, using the configuration latched at the first of the two. This gives 2, 4, 6 or 8 ticks at divider 0, and 16, 32, 48 or 64 at divider 7.
- R4: `frame_start` is high for exactly one cycle. That cycle directly follows the first tick of each frame.
- R5: Changes to `div_sel` or `mux_sel` during a frame have no effect until the next frame start. `mux_active` changes only in the cycle where `frame_start` is high, and it then shows the newly latched mode.
- R6: When `en` is low, the next cycle shows `com_idx` = 0 and `frame_start` = 0. After `en` rises, one cycle passes with no counting, and the next tick opens a new frame at common 0.
- R7: On cycles without a tick, the block holds: `com_idx` keeps its value and no frame start is produced.
- R8: After reset, `frame_start` = 0, `com_idx` = 0 and `mux_active` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks the block and clears the counters |
| tick | input | 1 | Prescaled LCD clock tick, one cycle wide |
| div_sel | input | DIV_W (3) | Frame divider; a phase lasts div_sel+1 ticks |
| mux_sel | input | MUX_W (2) | Requested multiplex mode (0 static .. 3 quadruplex) |
| frame_start | output | 1 | One-cycle strobe after the first tick of a frame |
| com_idx | output | MUX_W (2) | Common currently driven |
| mux_active | output | MUX_W (2) | Multiplex mode in force for the current frame |

## Verification
The assertions assume that `en`, `tick`, `div_sel` and `mux_sel` are synchronous to `clk` and never unknown once reset is released. They also assume reset is asserted before any checking starts. They place no limit on how densely ticks arrive: a tick on every cycle is legal. The stimulus changes every input only on the falling clock edge. It covers back-to-back ticks, sparse random ticks and long tick-free gaps. It also changes the divider and mode mid-frame and drops `en` mid-frame. All these patterns stay within those assumptions.

// File: rtl/lcd_ft_pkg.sv
package lcd_ft_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_START = 2'd1,
        ST_POS   = 2'd2,
        ST_NEG   = 2'd3
    } ft_state_e;

endpackage

// File: rtl/lcd_ft_wrap_ctr.sv
module lcd_ft_wrap_ctr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         at_limit
);

    assign at_limit = (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= at_limit ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_ft_cfg_hold.sv
module lcd_ft_cfg_hold #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
    parameter int DIV_W = 3,
    parameter int MUX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [MUX_W-1:0] mux_sel,
    output logic             frame_start,
    output logic [MUX_W-1:0] com_idx,
    output logic [MUX_W-1:0] mux_active
);
    import lcd_ft_pkg::*;

    ft_state_e        state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_use;
    logic [MUX_W-1:0] mux_use;
    logic [DIV_W-1:0] tick_cnt;
    logic             tick_last;
    logic             com_last;
    logic             at_start;
    logic             counting;
    logic             hold_clr;
    logic             phase_end;
    logic             half_end;
    logic             cfg_load;

    // A frame's first tick runs on the requested settings; later ticks on the latched ones.
    assign at_start  = (state_q == ST_START);
    assign div_use   = at_start ? div_sel : div_q;
    assign mux_use   = at_start ? mux_sel : mux_active;
    assign counting  = en && tick && (state_q != ST_OFF);
    assign hold_clr  = !en || (state_q == ST_OFF);
    assign phase_end = counting && tick_last;
    assign half_end  = phase_end && com_last;
    assign cfg_load  = at_start && counting;

    lcd_ft_wrap_ctr #(.W(DIV_W)) u_tick_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hold_clr),
        .adv      (counting),
        .limit    (div_use),
        .cnt      (tick_cnt),
        .at_limit (tick_last)
    );

    lcd_ft_wrap_ctr #(.W(MUX_W)) u_com_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hold_clr),
        .adv      (phase_end),
        .limit    (mux_use),
        .cnt      (com_idx),
        .at_limit (com_last)
    );

    lcd_ft_cfg_hold #(.W(DIV_W)) u_div_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load),
        .d     (div_sel),
        .q     (div_q)
    );

    lcd_ft_cfg_hold #(.W(MUX_W)) u_mux_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load),
        .d     (mux_sel),
        .q     (mux_active)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_START;
                ST_START: if (counting) state_d = half_end ? ST_NEG : ST_POS;
                ST_POS:   if (half_end) state_d = ST_NEG;
                ST_NEG:   if (half_end) state_d = ST_START;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered strobe output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
        end else begin
            frame_start <= cfg_load;
        end
    end

endmodule

// File: rtl/lcd_ft_checker.sv
module lcd_ft_checker #(
    parameter int MUX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tick,
    input logic             frame_start,
    input logic [MUX_W-1:0] com_idx,
    input logic [MUX_W-1:0] mux_active
);

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> !frame_start); // R4
    AST_FS_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) frame_start |-> ($past(tick) && $past(en))); // R4
    AST_COM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) com_idx <= mux_active); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (en && $past(en) && !$past(tick)) |-> ($stable(com_idx) && !frame_start)); // R7
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !$past(en) |-> (com_idx == '0 && !frame_start)); // R6
    AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !frame_start |-> $stable(mux_active)); // R5

endmodule

bind lcd_frame_timer lcd_ft_checker #(.MUX_W(MUX_W)) u_ft_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .tick        (tick),
    .frame_start (frame_start),
    .com_idx     (com_idx),
    .mux_active  (mux_active)
);

// File: tb/tb_lcd_frame_timer.sv
module tb_lcd_frame_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic [1:0] mux_sel = 2'd0;
    logic       frame_start;
    logic [1:0] com_idx;
    logic [1:0] mux_active;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    bit m_on = 0;
    int k = 0;
    int m_cd = 0;
    int m_cm = 0;
    bit m_fs = 0;
    int m_com = 0;
    int ticks_total = 0;
    bit seg_break = 1;
    bit have_prev = 0;
    int prev_total = 0;
    int prev_per = 0;

    always #2 clk = ~clk;

    lcd_frame_timer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .tick        (tick),
        .div_sel     (div_sel),
        .mux_sel     (mux_sel),
        .frame_start (frame_start),
        .com_idx     (com_idx),
        .mux_active  (mux_active)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; k = 0; m_fs = 0; m_com = 0; m_cd = 0; m_cm = 0; seg_break = 1;
        end else if (!en) begin
            m_on = 0; k = 0; m_fs = 0; m_com = 0; seg_break = 1;
        end else if (!m_on) begin
            m_on = 1; m_fs = 0;
        end else if (tick) begin
            if (k == 0) begin
                m_cd = int'(div_sel); m_cm = int'(mux_sel); m_fs = 1;
            end else begin
                m_fs = 0;
            end
            k = k + 1;
            if (k == (m_cd + 1) * 2 * (m_cm + 1)) k = 0;
            m_com = (k / (m_cd + 1)) % (m_cm + 1);
            ticks_total = ticks_total + 1;
        end else begin
            m_fs = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(frame_start === m_fs, "R4 frame_start", int'(frame_start), int'(m_fs));
        chk(com_idx === 2'(m_com), "R1/R2 com_idx", int'(com_idx), m_com);
        chk(mux_active === 2'(m_cm), "R5 mux_active", int'(mux_active), m_cm);
        if (seg_break) begin
            have_prev = 0; seg_break = 0;
        end
        if (frame_start === 1'b1) begin
            if (have_prev) chk(ticks_total - prev_total == prev_per, "R3 frame period ticks",
                               ticks_total - prev_total, prev_per);
            prev_total = ticks_total;
            prev_per = (m_cd + 1) * 2 * (m_cm + 1);
            have_prev = 1;
        end
    endtask

    task automatic cyc(input bit t);
        tick = t;
        @(negedge clk);
        compare();
    endtask

    task automatic run_dense(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    task automatic run_sparse(input int n);
        for (int i = 0; i < n; i++) cyc(($urandom % 3) == 0);
    endtask

    task automatic drop_en();
        en = 1'b0;
        cyc(1'b1);
        chk(com_idx == 2'd0 && frame_start == 1'b0, "R6 cleared while disabled",
            int'(com_idx), 0);
        cyc(1'b0);
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic [1:0] held_com;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(frame_start == 1'b0, "R8 frame_start after reset", int'(frame_start), 0);
        chk(com_idx == 2'd0, "R8 com_idx after reset", int'(com_idx), 0);
        chk(mux_active == 2'd0, "R8 mux_active after reset", int'(mux_active), 0);

        // R1, R2, R3: every mode and divider with a tick on each cycle, then sparse ticks
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 8; d++) begin
                mux_sel = 2'(m);
                div_sel = 3'(d);
                en = 1'b1;
                run_dense(3 * (d + 1) * 2 * (m + 1) + 3);
                if (d == 0 || d == 7) run_sparse(6 * (d + 1) * (m + 1) + 4);
                drop_en();
            end
        end

        // R6: first tick after enabling opens a frame at common 0
        mux_sel = 2'd2; div_sel = 3'd1; en = 1'b1;
        cyc(1'b1);
        chk(frame_start == 1'b0, "R6 no count in arming cycle", int'(frame_start), 0);
        cyc(1'b1);
        chk(frame_start == 1'b1, "R6 first tick starts frame", int'(frame_start), 1);
        chk(mux_active == 2'd2, "R6 mode latched at start", int'(mux_active), 2);

        // R5: mid-frame change ignored until next frame start
        run_dense(3);
        mux_sel = 2'd0; div_sel = 3'd0;
        run_dense(2);
        chk(mux_active == 2'd2, "R5 mode held mid-frame", int'(mux_active), 2);
        chk(com_idx == 2'd0, "R5 divider held mid-frame", int'(com_idx), 0);
        run_dense(7);
        chk(frame_start == 1'b1 && mux_active == 2'd0, "R5 new mode at frame start",
            int'(mux_active), 0);
        run_dense(9);

        // R7: no ticks, nothing moves
        mux_sel = 2'd3; div_sel = 3'd2;
        run_dense(8);
        held_com = com_idx;
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0);
            chk(com_idx == held_com && frame_start == 1'b0, "R7 hold without tick",
                int'(com_idx), int'(held_com));
        end
        run_sparse(300);

        // R6: disable mid-frame then resume
        drop_en();
        en = 1'b1;
        run_dense(40);
        run_sparse(200);

        done = 1;
        report();
    end

endmodule